// File: doc/BRIEF.md
# Register-Launched Single-Transfer Bus Bridge

This block sits between a 64-bit register port and a 32-bit-address peripheral bus. Software first places the outgoing data in a data register. It then writes one control word, and that single write starts exactly one read or write of 1, 2 or 4 bytes on the peripheral side. Only one transfer can be in flight at a time, and there is no queue behind it.

Progress is tracked in a single status word. This word holds a busy flag, a done flag, three independent error fields and the returned read data. Software polls the word until done is set. Any nonzero error field at that point means the transfer failed. Outgoing data is taken from the upper end of the data register, and incoming data is placed at the upper end of the read field.

Top module: `regbus_xact_bridge`

## Requirements
- R1: After reset, the status word reads zero, the data register reads zero and `bus_req` is low.
- R2: Software can launch a transfer by writing the control register at offset 0 while idle, using a word with marker 0xD in bits 63:60, size 1, 2 or 4 in bits 59:56, read flag in bit 48, address length code 4 in bits 40:38 and bus address in bits 31:0. On the next cycle `bus_req` is high, with that address, `bus_we` equal to the inverse of the read flag, and `bus_size` equal to the size. In the same cycle, status shows busy (bit 19) set and done (bit 11) clear.
- R3: For a write, `bus_wdata` is right-justified and comes from the top of the data register at offset 3. Size 1 uses bits 63:56, size 2 uses bits 63:48 and size 4 uses bits 63:32.
- R4: For a read, the returned right-justified `bus_rdata` is placed at the top of status bits 57:26. Size 1 puts the byte in the top 8 bits, size 2 puts it in the top 16 bits, and size 4 fills all 32 bits. The remaining bits are zero.
- R5: `bus_ack` on an active request ends it. On the next cycle `bus_req` is low, busy is clear and done is set.
- R6: The 6-bit `bus_err` code sampled with the acknowledge is stored in status bits 63:58. Done is still set.
- R7: A control write with a bad marker, size or address length does not raise `bus_req` and sets done at once. It records its cause in status bits 18:12: bit 12 for the marker, bit 13 for the size and bit 14 for the address length.
- R8: A control write while busy is ignored: the request, its address and the control readback stay as they were. The write sets status bit 8, in the 3-bit field at bits 10:8, and this bit is cleared by the next accepted control write.
- R9: Done stays set until the next accepted control write, and writes to the data register do not clear it.
- R10: Offset 0 reads back the last accepted control word, offset 2 reads status, offset 3 reads the data register and offset 1 reads zero.
- R11: While `bus_req` is high and `bus_ack` is low, the request and all of its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on `reg_addr`) |
| bus_req | output | 1 | Peripheral request, held until acknowledge |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 32 | Peripheral byte address |
| bus_size | output | 3 | Transfer size in bytes (1, 2 or 4) |
| bus_wdata | output | 32 | Right-justified write data |
| bus_ack | input | 1 | Peripheral acknowledge |
| bus_err | input | 6 | Peripheral error code, valid with acknowledge |
| bus_rdata | input | 32 | Right-justified read data, valid with acknowledge |

## Verification
Completion of a transfer and the arrival of a new control write can fall in the same clock edge. The bench provokes this by driving `bus_ack` and a fresh control word in one cycle. The expected result is that the acknowledge completes the original transfer with its own data and error code. The new word is dropped, and the dropped write is visible in status bit 8 and in the unchanged control readback.

// File: rtl/regbus_xact_bridge.sv
module regbus_xact_bridge #(
  parameter int          BUS_AW  = 32,
  parameter int          BUS_DW  = 32,
  parameter int          BERR_W  = 6,
  parameter logic [3:0]  MARKER  = 4'hD,
  parameter logic [2:0]  ALEN_OK = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [BERR_W-1:0] bus_err,
  input  logic [BUS_DW-1:0] bus_rdata
);
  localparam logic [1:0] OFF_CTL = 2'd0;
  localparam logic [1:0] OFF_STS = 2'd2;
  localparam logic [1:0] OFF_DAT = 2'd3;
  localparam int PAD_W = 64 - BERR_W - BUS_DW - 1 - 7 - 1 - 3 - 8;

  logic [63:0]       ctl_q, dat_q;
  logic              busy_q, done_q;
  logic [BERR_W-1:0] berr_q;
  logic [6:0]        cerr_q;
  logic [2:0]        xerr_q;
  logic [BUS_DW-1:0] rd_q;

  wire wr_any = reg_valid & reg_write;
  wire ctl_wr = wr_any && (reg_addr == OFF_CTL);
  wire dat_wr = wr_any && (reg_addr == OFF_DAT);

  wire [3:0] f_mark = reg_wdata[63:60];
  wire [3:0] f_size = reg_wdata[59:56];
  wire       f_read = reg_wdata[48];
  wire [2:0] f_alen = reg_wdata[40:38];

  wire       size_ok = (f_size == 4'd1) || (f_size == 4'd2) || (f_size == 4'd4);
  wire [2:0] bad     = {f_alen != ALEN_OK, !size_ok, f_mark != MARKER};

  logic [BUS_DW-1:0] wlane, rlane;
  always_comb begin
    case (f_size)
      4'd1:    wlane = {{(BUS_DW-8){1'b0}},  dat_q[63:56]};
      4'd2:    wlane = {{(BUS_DW-16){1'b0}}, dat_q[63:48]};
      default: wlane = dat_q[63:64-BUS_DW];
    endcase
    case (bus_size)
      3'd1:    rlane = {bus_rdata[7:0],  {(BUS_DW-8){1'b0}}};
      3'd2:    rlane = {bus_rdata[15:0], {(BUS_DW-16){1'b0}}};
      default: rlane = bus_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; dat_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
      berr_q <= '0; cerr_q <= '0; xerr_q <= '0; rd_q <= '0;
      bus_we <= 1'b0; bus_addr <= '0; bus_size <= '0; bus_wdata <= '0;
    end else begin
      if (dat_wr) dat_q <= reg_wdata;
      if (ctl_wr && !busy_q) begin
        ctl_q  <= reg_wdata;
        berr_q <= '0;
        xerr_q <= '0;
        rd_q   <= '0;
        cerr_q <= {4'b0, bad};
        if (|bad) begin
          done_q <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          done_q    <= 1'b0;
          bus_we    <= !f_read;
          bus_addr  <= reg_wdata[BUS_AW-1:0];
          bus_size  <= f_size[2:0];
          bus_wdata <= wlane;
        end
      end else begin
        if (ctl_wr) xerr_q[0] <= 1'b1;
        if (busy_q && bus_ack) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          berr_q <= bus_err;
          if (!bus_we) rd_q <= rlane;
        end
      end
    end
  end

  assign bus_req = busy_q;

  wire [63:0] status = {berr_q, rd_q, {PAD_W{1'b0}}, busy_q, cerr_q, done_q, xerr_q, 8'b0};

  always_comb begin
    case (reg_addr)
      OFF_CTL: reg_rdata = ctl_q;
      OFF_STS: reg_rdata = status;
      OFF_DAT: reg_rdata = dat_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                             && $stable(bus_size) && $stable(bus_wdata));
  a_r5_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req && done_q);
  a_r7_bad_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !bus_req && (|bad) |=> !bus_req && done_q);
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !bus_req && !(|bad) |=> bus_req && !done_q);
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && bus_req |=> $stable(ctl_q) && xerr_q[0]);
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ctl_wr |=> done_q);
endmodule

// File: tb/regbus_xact_bridge_tb.sv
`timescale 1ns/1ps
module regbus_xact_bridge_tb;
  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_write = 0;
  logic [1:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic bus_req, bus_we, bus_ack = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [2:0] bus_size;
  logic [5:0] bus_err = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regbus_xact_bridge u_dut (.clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_wdata,
    .reg_rdata, .bus_req, .bus_we, .bus_addr, .bus_size, .bus_wdata, .bus_ack,
    .bus_err, .bus_rdata);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [3:0] m, logic [3:0] s, logic r,
                                     logic [2:0] al, logic [31:0] a);
    logic [63:0] c = '0;
    c[63:60] = m; c[59:56] = s; c[48] = r; c[40:38] = al; c[31:0] = a;
    return c;
  endfunction

  task automatic rw(logic [1:0] a, logic [63:0] d);
    @(negedge clk); reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_valid = 0; reg_write = 0;
  endtask

  task automatic rr(logic [1:0] a, output logic [63:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic logic [31:0] wexp(int sz, logic [63:0] d);
    if (sz == 1) return {24'h0, d[63:56]};
    if (sz == 2) return {16'h0, d[63:48]};
    return d[63:32];
  endfunction

  function automatic logic [31:0] rexp(int sz, logic [31:0] r);
    if (sz == 1) return {r[7:0], 24'h0};
    if (sz == 2) return {r[15:0], 16'h0};
    return r;
  endfunction

  task automatic xact(int sz, bit rd, logic [31:0] a, logic [63:0] wd,
                      logic [31:0] rdv, logic [5:0] ec, int dly);
    logic [63:0] st;
    rw(2'd3, wd);
    rw(2'd0, mk(4'hD, sz[3:0], rd, 3'd4, a));
    chk("R2 req", bus_req, 1); chk("R2 addr", bus_addr, a);
    chk("R2 we", bus_we, !rd); chk("R2 size", bus_size, sz[2:0]);
    rr(2'd2, st); chk("R2 busy", st[19], 1); chk("R2 done", st[11], 0);
    if (!rd) chk("R3 lane", bus_wdata, wexp(sz, wd));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); chk("R11 held", {bus_req, bus_addr}, {1'b1, a});
    end
    bus_ack = 1; bus_rdata = rdv; bus_err = ec;
    @(negedge clk); bus_ack = 0; bus_err = 0;
    chk("R5 req low", bus_req, 0);
    rr(2'd2, st);
    chk("R5 busy/done", {st[19], st[11]}, 2'b01);
    chk("R6 err", st[63:58], ec);
    chk("R4 rdata", st[57:26], rd ? rexp(sz, rdv) : 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] st, v, c0;
    repeat (3) @(negedge clk); rst_n = 1;
    rr(2'd2, st); chk("R1 status", st, 0);
    rr(2'd3, v); chk("R1 data", v, 0);
    chk("R1 req", bus_req, 0);

    for (int s = 1; s <= 4; s = s * 2)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 3; p++)
          xact(s, r[0], 32'h1000_0000 * (p + 1) + s * 16 + r,
               64'hA5C3_0F96_1234_5678 ^ (64'h1111_1111_1111_1111 * p),
               32'h8E4D_B271 + 32'h0101_0101 * p,
               (p == 2) ? 6'h2A : 6'h0, p);

    for (int s = 0; s < 16; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      rw(2'd0, mk(4'hD, s[3:0], 0, 3'd4, 32'h55));
      chk("R7 size no req", bus_req, 0);
      rr(2'd2, st); chk("R7 size code", {st[18:12], st[11]}, {7'b0000010, 1'b1});
    end
    for (int m = 0; m < 16; m++) begin
      if (m == 13) continue;
      rw(2'd0, mk(m[3:0], 4'd1, 1, 3'd4, 32'h66));
      chk("R7 marker no req", bus_req, 0);
      rr(2'd2, st); chk("R7 marker code", st[18:12], 7'b0000001);
    end
    for (int al = 0; al < 8; al++) begin
      if (al == 4) continue;
      rw(2'd0, mk(4'hD, 4'd4, 0, al[2:0], 32'h77));
      chk("R7 alen no req", bus_req, 0);
      rr(2'd2, st); chk("R7 alen code", st[18:12], 7'b0000100);
    end
    rw(2'd0, mk(4'h3, 4'd3, 0, 3'd4, 32'h0));
    rr(2'd2, st); chk("R7 combined", st[18:12], 7'b0000011);

    c0 = mk(4'hD, 4'd2, 1, 3'd4, 32'hCAFE_0000);
    rw(2'd0, c0);
    rw(2'd0, mk(4'hD, 4'd1, 0, 3'd4, 32'hDEAD_0000));
    chk("R8 addr kept", bus_addr, 32'hCAFE_0000);
    chk("R8 still req", bus_req, 1);
    rr(2'd0, v); chk("R8 ctl kept", v, c0);
    rr(2'd2, st); chk("R8 flag", st[8], 1);
    @(negedge clk);
    bus_ack = 1; bus_rdata = 32'h0000_BEEF; bus_err = 6'h05;
    reg_valid = 1; reg_write = 1; reg_addr = 0; reg_wdata = mk(4'hD, 4'd4, 0, 3'd4, 32'h1);
    @(negedge clk); bus_ack = 0; bus_err = 0; reg_valid = 0; reg_write = 0;
    chk("R8 collide no req", bus_req, 0);
    rr(2'd2, st);
    chk("R8 collide done", st[11], 1);
    chk("R8 collide rdata", st[57:26], 32'hBEEF_0000);
    chk("R6 collide err", st[63:58], 6'h05);
    chk("R8 collide flag", st[10:8], 3'b001);
    rr(2'd0, v); chk("R8 collide ctl", v, c0);

    rw(2'd3, 64'h0123_4567_89AB_CDEF);
    repeat (4) @(negedge clk);
    rr(2'd2, st); chk("R9 done holds", st[11], 1);
    rr(2'd3, v); chk("R10 data rb", v, 64'h0123_4567_89AB_CDEF);
    rr(2'd1, v); chk("R10 hole", v, 0);
    rw(2'd0, mk(4'hD, 4'd1, 0, 3'd4, 32'h42));
    rr(2'd2, st); chk("R9 cleared", {st[11], st[10:8]}, 4'b0000);
    chk("R3 byte lane", bus_wdata, 32'h0000_0001);
    bus_ack = 1; @(negedge clk); bus_ack = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule